// File: doc/BRIEF.md
# Next-Branch Address Predictor

This block guesses where the next branch of an instruction trace will sit, given the resolved outcome of the current branch. It keeps two last-value maps. When the current branch was taken, its target address is the key into the taken map. When it fell through, the branch's own address is the key into a separate fall-through map. Because of this split, the taken and not-taken outcomes of one branch never overwrite each other's entry. Each entry holds a valid bit, the full key as a tag, and the address of the branch that followed the last time that key was seen.

A requester offers either a lookup (branch address, target, taken bit) or an update (the same fields plus the branch that actually came next). One operation is handled at a time. The key is folded into a home slot. The controller then walks a bounded window of slots, one per clock, starting at the home slot and wrapping modulo the table depth. A lookup ends in a one-cycle response carrying a hit flag and the predicted address. An update stores the new address at the matching slot, at the first free slot, or at the home slot when the window is full. The cost per operation is a fixed number of cycles, whatever the length of the trace.

The controller has four states. IDLE accepts a request and goes to PROBE. PROBE examines one slot per cycle. It goes to RESP for a lookup, or to WRITE for an update, as soon as a slot matches, a slot is empty, or the last slot of the window has been examined; otherwise it stays in PROBE and advances to the next slot. RESP and WRITE each last one cycle and return to IDLE.

Top module: `nbp_next_addr`

## Requirements
- R1: A lookup with the taken bit set (lk_taken=1) uses lk_target as key into the taken map, ignores lk_pc, and, if an entry for that key exists, responds with resp_hit=1 and the stored next-branch address.
- R2: A lookup or update with the taken bit clear uses the branch address as key into a separate fall-through map. Writes to one map never change what the other map returns.
- R3: An update for a key already present replaces its stored address, so a later lookup returns the most recent value only.
- R4: A key whose home slot is occupied by another key goes to the following slots (modulo DEPTH, wrapping past the last slot) within a window of WIN slots. A lookup finds a key anywhere in that window.
- R5: An update that finds neither its key nor a free slot in the window overwrites the home slot. The evicted key then misses, and the other keys in the window still hit.
- R6: A lookup that misses responds with resp_hit=0 and resp_addr equal to zero.
- R7: The home slot index is an XOR fold of the key: index bit j is the XOR of all key bits i with i mod log2(DEPTH) equal to j.
- R8: req_ready is high only in IDLE. An accepted request lowers it on the next cycle. resp_valid is a single-cycle pulse k+1 cycles after the lookup is accepted, where k is the window offset of the matching or first empty slot, or WIN-1 when the whole window is examined.
- R9: When up_valid and lk_valid are both high while req_ready is high, the update is accepted and the lookup is not; the lookup waits and is served afterwards.
- R10: Reset empties both maps and returns the controller to IDLE with no response pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_taken | input | 1 | Resolved direction of the current branch |
| lk_pc | input | AW | Current branch address |
| lk_target | input | AW | Current branch target |
| up_valid | input | 1 | Update request |
| up_taken | input | 1 | Direction of the branch being trained |
| up_pc | input | AW | Address of the branch being trained |
| up_target | input | AW | Target of the branch being trained |
| up_next | input | AW | Address of the branch that actually followed |
| req_ready | output | 1 | Controller idle, a request is taken this cycle |
| resp_valid | output | 1 | Lookup response pulse |
| resp_hit | output | 1 | Valid entry with matching tag found |
| resp_addr | output | AW | Predicted next-branch address, zero on miss |

## Verification
The hardest case to reach from the ports is a home slot whose whole probe window is occupied by other keys. Only then can eviction, a lookup that walks to the last slot, and wrap-around past the top slot be observed. The stimulus builds this case from keys that differ only in bits folding onto the same index bit (for example, flipping bits 0 and 4 together with a 16-entry table), so that five distinct keys share one home slot. A second pair of keys is placed at home slot 15 to force the wrap to slot 0. Latency measured in cycles from acceptance to response then shows the offset at which each key was found.

// File: rtl/nbp_pkg.sv
`timescale 1ns/1ps
package nbp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_WRITE = 2'd2,
        ST_RESP  = 2'd3
    } nbp_state_e;

    typedef enum logic {
        OP_LOOKUP = 1'b0,
        OP_UPDATE = 1'b1
    } nbp_op_e;

    localparam logic SEL_FALL  = 1'b0;
    localparam logic SEL_TAKEN = 1'b1;

endpackage

// File: rtl/nbp_hash.sv
`timescale 1ns/1ps
module nbp_hash #(
    parameter int AW = 32,
    parameter int IW = 4
) (
    input  logic [AW-1:0] key,
    output logic [IW-1:0] idx
);
    // every key bit lands on index bit (position mod IW)
    always_comb begin
        idx = '0;
        for (int i = 0; i < AW; i++) begin
            idx[i % IW] = idx[i % IW] ^ key[i];
        end
    end
endmodule

// File: rtl/nbp_table.sv
`timescale 1ns/1ps
module nbp_table #(
    parameter int AW    = 32,
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_vld,
    output logic [AW-1:0] rd_tag,
    output logic [AW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_tag,
    input  logic [AW-1:0] wr_data
);
    logic [DEPTH-1:0] vld_q;
    logic [AW-1:0]    tag_q [DEPTH];
    logic [AW-1:0]    dat_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int e = 0; e < DEPTH; e++) begin
                tag_q[e] <= '0;
                dat_q[e] <= '0;
            end
        end else if (wr_en) begin
            for (int e = 0; e < DEPTH; e++) begin
                if (wr_idx == IW'(e)) begin
                    vld_q[e] <= 1'b1;
                    tag_q[e] <= wr_tag;
                    dat_q[e] <= wr_data;
                end
            end
        end
    end

    assign rd_vld  = vld_q[rd_idx];
    assign rd_tag  = tag_q[rd_idx];
    assign rd_data = dat_q[rd_idx];
endmodule

// File: rtl/nbp_ctrl.sv
`timescale 1ns/1ps
module nbp_ctrl
    import nbp_pkg::*;
#(
    parameter int AW  = 32,
    parameter int IW  = 4,
    parameter int WIN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_valid,
    input  logic          lk_valid,
    input  logic [AW-1:0] in_key,
    input  logic          in_sel,
    input  logic [IW-1:0] in_home,
    input  logic [AW-1:0] up_next,
    input  logic          slot_vld,
    input  logic [AW-1:0] slot_tag,
    input  logic [AW-1:0] slot_data,
    output logic [IW-1:0] probe_idx,
    output logic          probe_sel,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [AW-1:0] wr_tag,
    output logic [AW-1:0] wr_data,
    output logic          req_ready,
    output logic          resp_valid,
    output logic          resp_hit,
    output logic [AW-1:0] resp_addr
);
    localparam int OW = (WIN > 1) ? $clog2(WIN) : 1;

    nbp_state_e    st_q, st_d;
    nbp_op_e       op_q;
    logic          sel_q;
    logic [AW-1:0] key_q;
    logic [AW-1:0] data_q;
    logic [IW-1:0] home_q;
    logic [OW-1:0] off_q;
    logic [IW-1:0] tgt_q;
    logic          hit_q;
    logic [AW-1:0] addr_q;

    logic slot_match, slot_empty, last_slot, stop;

    assign probe_idx  = home_q + IW'(off_q);
    assign probe_sel  = sel_q;
    assign slot_match = slot_vld && (slot_tag == key_q);
    assign slot_empty = !slot_vld;
    assign last_slot  = (off_q == OW'(WIN - 1));
    assign stop       = slot_match || slot_empty || last_slot;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (up_valid || lk_valid) st_d = ST_PROBE;
            ST_PROBE: if (stop) st_d = (op_q == OP_UPDATE) ? ST_WRITE : ST_RESP;
            ST_WRITE: st_d = ST_IDLE;
            ST_RESP:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // request and probe datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_LOOKUP;
            sel_q  <= SEL_FALL;
            key_q  <= '0;
            data_q <= '0;
            home_q <= '0;
            off_q  <= '0;
            tgt_q  <= '0;
            hit_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (up_valid || lk_valid) begin
                        op_q   <= up_valid ? OP_UPDATE : OP_LOOKUP;
                        sel_q  <= in_sel;
                        key_q  <= in_key;
                        data_q <= up_next;
                        home_q <= in_home;
                        off_q  <= '0;
                    end
                end
                ST_PROBE: begin
                    if (stop) begin
                        hit_q  <= slot_match;
                        addr_q <= slot_match ? slot_data : '0;
                        tgt_q  <= (slot_match || slot_empty) ? probe_idx : home_q;
                    end else begin
                        off_q <= off_q + OW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = (st_q == ST_IDLE);
        resp_valid = (st_q == ST_RESP);
        resp_hit   = (st_q == ST_RESP) && hit_q;
        resp_addr  = (st_q == ST_RESP) ? addr_q : '0;
        wr_en      = (st_q == ST_WRITE);
        wr_idx     = tgt_q;
        wr_tag     = key_q;
        wr_data    = data_q;
    end
endmodule

// File: rtl/nbp_next_addr.sv
`timescale 1ns/1ps
module nbp_next_addr
    import nbp_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 16,
    parameter int WIN   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lk_valid,
    input  logic          lk_taken,
    input  logic [AW-1:0] lk_pc,
    input  logic [AW-1:0] lk_target,
    input  logic          up_valid,
    input  logic          up_taken,
    input  logic [AW-1:0] up_pc,
    input  logic [AW-1:0] up_target,
    input  logic [AW-1:0] up_next,
    output logic          req_ready,
    output logic          resp_valid,
    output logic          resp_hit,
    output logic [AW-1:0] resp_addr
);
    localparam int IW   = $clog2(DEPTH);
    localparam int NTBL = 2;

    logic [AW-1:0] lk_key, up_key, in_key;
    logic          in_sel;
    logic [IW-1:0] in_home;

    // taken outcome keys on target, fall-through keys on branch address
    assign lk_key = lk_taken ? lk_target : lk_pc;
    assign up_key = up_taken ? up_target : up_pc;
    assign in_key = up_valid ? up_key : lk_key;
    assign in_sel = up_valid ? up_taken : lk_taken;

    nbp_hash #(.AW(AW), .IW(IW)) u_hash (
        .key (in_key),
        .idx (in_home)
    );

    logic [IW-1:0] probe_idx, wr_idx;
    logic          probe_sel, wr_en;
    logic [AW-1:0] wr_tag, wr_data;
    logic          t_vld  [NTBL];
    logic [AW-1:0] t_tag  [NTBL];
    logic [AW-1:0] t_data [NTBL];

    for (genvar g = 0; g < NTBL; g++) begin : g_tbl
        nbp_table #(.AW(AW), .DEPTH(DEPTH), .IW(IW)) u_tbl (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_idx  (probe_idx),
            .rd_vld  (t_vld[g]),
            .rd_tag  (t_tag[g]),
            .rd_data (t_data[g]),
            .wr_en   (wr_en && (probe_sel == 1'(g))),
            .wr_idx  (wr_idx),
            .wr_tag  (wr_tag),
            .wr_data (wr_data)
        );
    end

    nbp_ctrl #(.AW(AW), .IW(IW), .WIN(WIN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_valid   (up_valid),
        .lk_valid   (lk_valid),
        .in_key     (in_key),
        .in_sel     (in_sel),
        .in_home    (in_home),
        .up_next    (up_next),
        .slot_vld   (t_vld[probe_sel]),
        .slot_tag   (t_tag[probe_sel]),
        .slot_data  (t_data[probe_sel]),
        .probe_idx  (probe_idx),
        .probe_sel  (probe_sel),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_tag     (wr_tag),
        .wr_data    (wr_data),
        .req_ready  (req_ready),
        .resp_valid (resp_valid),
        .resp_hit   (resp_hit),
        .resp_addr  (resp_addr)
    );
endmodule

// File: rtl/nbp_next_addr_chk.sv
`timescale 1ns/1ps
module nbp_next_addr_chk #(
    parameter int AW  = 32,
    parameter int WIN = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lk_valid,
    input logic          up_valid,
    input logic          req_ready,
    input logic          resp_valid,
    input logic          resp_hit,
    input logic [AW-1:0] resp_addr
);
    logic       pend_q;
    logic [7:0] wait_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            wait_q <= '0;
        end else if (req_ready && lk_valid && !up_valid) begin
            pend_q <= 1'b1;
            wait_q <= '0;
        end else if (resp_valid) begin
            pend_q <= 1'b0;
        end else if (pend_q && wait_q != 8'hFF) begin
            wait_q <= wait_q + 8'd1;
        end
    end

    p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_hit |-> resp_addr == '0);

    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready && (up_valid || lk_valid) |=> !req_ready);

    p_resp_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> wait_q <= 8'(WIN));

    // R9: an update accepted alongside a lookup produces no response
    p_resp_only_for_lookup_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> pend_q);

    p_no_hit_outside_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> resp_valid);
endmodule

bind nbp_next_addr nbp_next_addr_chk #(.AW(AW), .WIN(WIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .up_valid   (up_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_addr  (resp_addr)
);

// File: tb/nbp_next_addr_tb.sv
`timescale 1ns/1ps
module nbp_next_addr_tb;
    localparam int AW = 32;
    localparam int NV = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0, lk_taken = 1'b0;
    logic [AW-1:0] lk_pc = '0, lk_target = '0;
    logic          up_valid = 1'b0, up_taken = 1'b0;
    logic [AW-1:0] up_pc = '0, up_target = '0, up_next = '0;
    logic          req_ready, resp_valid, resp_hit;
    logic [AW-1:0] resp_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    nbp_next_addr #(.AW(AW), .DEPTH(16), .WIN(4)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_taken(lk_taken), .lk_pc(lk_pc), .lk_target(lk_target),
        .up_valid(up_valid), .up_taken(up_taken), .up_pc(up_pc), .up_target(up_target),
        .up_next(up_next),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_addr(resp_addr)
    );

    typedef struct packed {
        logic        upd;
        logic        tk;
        logic [31:0] pc;
        logic [31:0] tg;
        logic [31:0] nx;
        logic        ehit;
        logic [31:0] eaddr;
        logic [3:0]  elat;
        logic [3:0]  req;
    } vec_t;

    // Keys 0x2000, 0x2011, 0x2022, 0x2044, 0x2088 share home slot 2 (R7);
    // 0xF and 0x1E share home slot 15, so the second wraps to slot 0 (R4).
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 32'h100, 32'h2000, 32'h0,    1'b0, 32'h0,    4'd1, 4'd6}, // R6 empty
        '{1'b1, 1'b1, 32'h100, 32'h2000, 32'h2040, 1'b0, 32'h0,    4'd0, 4'd3},
        '{1'b0, 1'b1, 32'h999, 32'h2000, 32'h0,    1'b1, 32'h2040, 4'd1, 4'd1}, // R1 pc ignored
        '{1'b0, 1'b0, 32'h2000,32'h0,    32'h0,    1'b0, 32'h0,    4'd1, 4'd2}, // R2 other map
        '{1'b1, 1'b0, 32'h100, 32'h2000, 32'h108,  1'b0, 32'h0,    4'd0, 4'd2},
        '{1'b0, 1'b0, 32'h100, 32'h5555, 32'h0,    1'b1, 32'h108,  4'd1, 4'd2}, // R2
        '{1'b0, 1'b1, 32'h100, 32'h2000, 32'h0,    1'b1, 32'h2040, 4'd1, 4'd2}, // R2 untouched
        '{1'b1, 1'b1, 32'h104, 32'h2000, 32'h3000, 1'b0, 32'h0,    4'd0, 4'd3},
        '{1'b0, 1'b1, 32'h0,   32'h2000, 32'h0,    1'b1, 32'h3000, 4'd1, 4'd3}, // R3 last value
        '{1'b1, 1'b1, 32'h0,   32'h2011, 32'hA1,   1'b0, 32'h0,    4'd0, 4'd4},
        '{1'b1, 1'b1, 32'h0,   32'h2022, 32'hA2,   1'b0, 32'h0,    4'd0, 4'd4},
        '{1'b1, 1'b1, 32'h0,   32'h2044, 32'hA3,   1'b0, 32'h0,    4'd0, 4'd4},
        '{1'b0, 1'b1, 32'h0,   32'h2044, 32'h0,    1'b1, 32'hA3,   4'd4, 4'd4}, // R4 offset 3
        '{1'b0, 1'b1, 32'h0,   32'h2000, 32'h0,    1'b1, 32'h3000, 4'd1, 4'd4},
        '{1'b0, 1'b1, 32'h0,   32'h2022, 32'h0,    1'b1, 32'hA2,   4'd3, 4'd7}, // R7 same home
        '{1'b1, 1'b1, 32'h0,   32'h2088, 32'hA4,   1'b0, 32'h0,    4'd0, 4'd5},
        '{1'b0, 1'b1, 32'h0,   32'h2088, 32'h0,    1'b1, 32'hA4,   4'd1, 4'd5}, // R5 at home
        '{1'b0, 1'b1, 32'h0,   32'h2000, 32'h0,    1'b0, 32'h0,    4'd4, 4'd5}, // R5 evicted
        '{1'b0, 1'b1, 32'h0,   32'h2022, 32'h0,    1'b1, 32'hA2,   4'd3, 4'd5}, // R5 others kept
        '{1'b1, 1'b0, 32'hF,   32'h0,    32'hB1,   1'b0, 32'h0,    4'd0, 4'd4},
        '{1'b1, 1'b0, 32'h1E,  32'h0,    32'hB2,   1'b0, 32'h0,    4'd0, 4'd4},
        '{1'b0, 1'b0, 32'h1E,  32'h0,    32'h0,    1'b1, 32'hB2,   4'd2, 4'd4}, // R4 wrap
        '{1'b0, 1'b0, 32'hF,   32'h0,    32'h0,    1'b1, 32'hB1,   4'd1, 4'd7}, // R7 home 15
        '{1'b0, 1'b0, 32'h100, 32'h0,    32'h0,    1'b1, 32'h108,  4'd1, 4'd2}  // R2
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_update(input logic tk, input logic [31:0] pc, input logic [31:0] tg,
                             input logic [31:0] nx);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        up_valid = 1'b1; up_taken = tk; up_pc = pc; up_target = tg; up_next = nx;
        @(negedge clk);
        up_valid = 1'b0;
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_lookup(input logic tk, input logic [31:0] pc, input logic [31:0] tg,
                             output logic hit, output logic [31:0] addr, output int lat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        lk_valid = 1'b1; lk_taken = tk; lk_pc = pc; lk_target = tg;
        @(negedge clk);
        lk_valid = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!resp_valid);
        hit = resp_hit;
        addr = resp_addr;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic        h;
        logic [31:0] a;
        int          lat;
        string       tag;

        repeat (3) @(negedge clk);
        // R10: reset state
        chk(req_ready == 1'b1, "R10 ready after reset", 32'(req_ready), 32'd1);
        chk(resp_valid == 1'b0, "R10 no response in reset", 32'(resp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 ready in idle", 32'(req_ready), 32'd1);

        for (int i = 0; i < NV; i++) begin
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            if (VEC[i].upd) begin
                do_update(VEC[i].tk, VEC[i].pc, VEC[i].tg, VEC[i].nx);
            end else begin
                do_lookup(VEC[i].tk, VEC[i].pc, VEC[i].tg, h, a, lat);
                chk(h == VEC[i].ehit, {tag, " hit"}, 32'(h), 32'(VEC[i].ehit));
                chk(a == VEC[i].eaddr, {tag, " addr"}, a, VEC[i].eaddr);
                chk(lat == int'(VEC[i].elat), $sformatf("R8 vec%0d latency", i),
                    32'(lat), 32'(VEC[i].elat));
            end
        end

        // R8: response lasts one cycle
        @(negedge clk);
        chk(resp_valid == 1'b0, "R8 single-cycle response", 32'(resp_valid), 32'd0);

        // R9: update and lookup offered together, update first
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        up_valid = 1'b1; up_taken = 1'b1; up_pc = 32'h0; up_target = 32'h3000; up_next = 32'hC0;
        lk_valid = 1'b1; lk_taken = 1'b1; lk_pc = 32'h0; lk_target = 32'h3000;
        @(negedge clk);
        up_valid = 1'b0;
        chk(req_ready == 1'b0, "R9 update accepted, busy", 32'(req_ready), 32'd0);
        while (!req_ready) begin
            chk(resp_valid == 1'b0, "R9 no response for update", 32'(resp_valid), 32'd0);
            @(negedge clk);
        end
        @(negedge clk);
        lk_valid = 1'b0;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!resp_valid);
        chk(resp_hit == 1'b1, "R9 held lookup hit", 32'(resp_hit), 32'd1);
        chk(resp_addr == 32'hC0, "R9 held lookup sees update", resp_addr, 32'hC0);

        // R10: reset clears the maps
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_lookup(1'b1, 32'h0, 32'h2088, h, a, lat);
        chk(h == 1'b0, "R10 map cleared hit", 32'(h), 32'd0);
        chk(a == 32'h0, "R10 map cleared addr", a, 32'h0);
        do_lookup(1'b0, 32'h100, 32'h0, h, a, lat);
        chk(h == 1'b0, "R10 fall-through map cleared", 32'(h), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule